// File: doc/BRIEF.md
# Rotating Register Rename and Loop-Top Branch Unit

This unit translates register numbers written in instructions into physical register numbers for a register file whose upper part rotates. It serves two files: a 128-entry general file whose top 96 entries rotate, and a 64-entry predicate file whose top 48 entries rotate. Each file has its own rotating base. A physical number is the virtual number offset by the base, wrapping within the rotating range. Numbers below the rotating range pass through unchanged.

The same unit carries out the loop branches that move the bases. It holds a loop counter and an epilogue counter. A rotating loop-top branch first spends the loop counter (the prologue and kernel), then the epilogue counter (the drain). On every rotating iteration it supplies the value for the first rotating predicate, the stage predicate. That predicate switches pipeline stages on and off, so a modulo-scheduled loop needs no separate prologue or epilogue code.

A plain counted branch only spends the loop counter. A setup strobe loads both counters and clears both bases before a loop starts. The translations and the branch outcome are combinational from the current state. Counters and bases update on the clock edge that samples the strobe.

Top module: `rot_rename_loop`

## Requirements
- R1: General virtual numbers 0 to 31 and predicate virtual numbers 0 to 15 appear unchanged on `gr_phys` and `pr_phys`, whatever the bases hold.
- R2: For a general virtual number v of 32 or more, `gr_phys` = 32 + ((v − 32 + `gr_base_o`) mod 96). The base is an unsigned offset from 0 to 95, and 95 stands for −1, so with base 95 virtual 32 maps to 127.
- R3: For a predicate virtual number v of 16 or more, `pr_phys` = 16 + ((v − 16 + `pr_base_o`) mod 48). It uses its own base, 0 to 47.
- R4: Reset clears both counters and both bases. A `load_en` cycle writes `load_lc` and `load_ec`, sets both bases to 0, and overrides both branch strobes: `br_taken` and `stage_pred_we` stay 0 in that cycle.
- R5: A loop-top branch (`br_top`) with a non-zero loop counter decrements that counter, asserts `br_taken`, writes stage predicate value 1, and decrements both bases modulo their ranges (0 becomes 95 or 47). `stage_pred_val` is 1 only in this case and 0 in every other cycle.
- R6: A loop-top branch with the loop counter at 0 and the epilogue counter above 1 decrements the epilogue counter, asserts `br_taken`, writes stage predicate value 0, and rotates both bases.
- R7: A loop-top branch with the loop counter at 0 and the epilogue counter at 1 clears the epilogue counter, writes stage predicate value 0, and rotates both bases, but leaves `br_taken` at 0 (the loop falls through).
- R8: A loop-top branch with both counters at 0 changes no state, leaves `br_taken` at 0, and writes no stage predicate.
- R9: A counted branch (`br_cloop`) decrements a non-zero loop counter and asserts `br_taken`. With the loop counter at 0 it is not taken. It never changes the epilogue counter or either base and never writes the stage predicate.
- R10: When `br_top` and `br_cloop` arrive in the same cycle, only the loop-top branch acts.
- R11: After a load of loop counter 3 and epilogue counter 2, five loop-top branches are taken, taken, taken, taken, not taken. The loop counter goes 2, 1, 0, 0, 0 and the epilogue counter goes 2, 2, 2, 1, 0. The bases end at 91 and 43, which is −5 in each range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Loop setup strobe |
| load_lc | input | CNT_W | Loop counter value to load |
| load_ec | input | CNT_W | Epilogue counter value to load |
| br_top | input | 1 | Rotating loop-top branch strobe |
| br_cloop | input | 1 | Counted branch strobe, no rotation |
| gr_virt | input | 7 | General register number to translate |
| gr_phys | output | 7 | Physical general register number |
| pr_virt | input | 6 | Predicate number to translate |
| pr_phys | output | 6 | Physical predicate number |
| br_taken | output | 1 | Branch taken in this cycle |
| stage_pred_we | output | 1 | Write the stage predicate in this cycle |
| stage_pred_val | output | 1 | Value for the stage predicate |
| lc_o | output | CNT_W | Current loop counter |
| ec_o | output | CNT_W | Current epilogue counter |
| gr_base_o | output | 7 | Current general rotating base (unsigned offset) |
| pr_base_o | output | 6 | Current predicate rotating base (unsigned offset) |

## Verification
On every cycle the assertions check four things: static numbers pass through and rotated numbers stay inside the rotating range; each rotating branch moves both bases down by exactly one with wrap; the kernel, drain and exhausted cases give the right taken and stage-predicate outputs; and a counted branch leaves the bases and the epilogue counter alone. Two things are shown only by the bench's scenarios against its own model. The first is the exact modulo mapping at each base value, including base −1 mapping virtual 32 to physical 127. The second is the full prologue, kernel and epilogue run from a loaded 3/2 pair, and random mixes of setups, rotating branches and counted branches.

// File: rtl/rr_pkg.sv
`timescale 1ns/1ps
package rr_pkg;
    // Outcome of the branch logic in one cycle
    typedef enum logic [2:0] {
        RR_NONE   = 3'd0,  // no branch, or loop-top with both counters spent
        RR_KERNEL = 3'd1,  // loop counter spent, stage on
        RR_EPILOG = 3'd2,  // epilogue counter spent, still taken
        RR_DRAIN  = 3'd3,  // last epilogue step, falls through
        RR_COUNT  = 3'd4,  // counted branch taken
        RR_CFALL  = 3'd5   // counted branch not taken
    } rr_kind_e;
endpackage

// File: rtl/rr_rename.sv
`timescale 1ns/1ps
module rr_rename #(
    parameter int TOTAL  = 128,
    parameter int STATIC = 32
) (
    input  logic [$clog2(TOTAL)-1:0] base,
    input  logic [$clog2(TOTAL)-1:0] virt,
    output logic [$clog2(TOTAL)-1:0] phys
);
    localparam int W   = $clog2(TOTAL);
    localparam int ROT = TOTAL - STATIC;

    logic [W:0] off;

    always_comb begin
        // offset inside the rotating window, reduced once (both terms < ROT)
        off = {1'b0, virt} - (W+1)'(STATIC) + {1'b0, base};
        if (off >= (W+1)'(ROT)) off = off - (W+1)'(ROT);
        if (virt < W'(STATIC)) phys = virt;
        else                   phys = W'(off + (W+1)'(STATIC));
    end
endmodule

// File: rtl/rr_loop_ctl.sv
`timescale 1ns/1ps
module rr_loop_ctl #(
    parameter int CNT_W = 16
) (
    input  logic             br_top,
    input  logic             br_cloop,
    input  logic [CNT_W-1:0] lc,
    input  logic [CNT_W-1:0] ec,
    output rr_pkg::rr_kind_e kind,
    output logic             lc_dec,
    output logic             ec_dec,
    output logic             rotate,
    output logic             taken,
    output logic             pred_we,
    output logic             pred_val
);
    import rr_pkg::*;

    logic lc_nz, ec_gt1, ec_one;

    always_comb begin
        lc_nz  = (lc != '0);
        ec_one = (ec == CNT_W'(1));
        ec_gt1 = (ec > CNT_W'(1));

        // loop-top has priority over the counted branch
        kind = RR_NONE;
        if (br_top) begin
            if (lc_nz)       kind = RR_KERNEL;
            else if (ec_gt1) kind = RR_EPILOG;
            else if (ec_one) kind = RR_DRAIN;
            else             kind = RR_NONE;
        end else if (br_cloop) begin
            kind = lc_nz ? RR_COUNT : RR_CFALL;
        end

        lc_dec   = 1'b0;
        ec_dec   = 1'b0;
        rotate   = 1'b0;
        taken    = 1'b0;
        pred_we  = 1'b0;
        pred_val = 1'b0;
        case (kind)
            RR_KERNEL: begin
                lc_dec = 1'b1; rotate = 1'b1; taken = 1'b1;
                pred_we = 1'b1; pred_val = 1'b1;
            end
            RR_EPILOG: begin
                ec_dec = 1'b1; rotate = 1'b1; taken = 1'b1; pred_we = 1'b1;
            end
            RR_DRAIN: begin
                ec_dec = 1'b1; rotate = 1'b1; pred_we = 1'b1;
            end
            RR_COUNT: begin
                lc_dec = 1'b1; taken = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rot_rename_loop.sv
`timescale 1ns/1ps
module rot_rename_loop #(
    parameter int GR_TOTAL  = 128,
    parameter int GR_STATIC = 32,
    parameter int PR_TOTAL  = 64,
    parameter int PR_STATIC = 16,
    parameter int CNT_W     = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_en,
    input  logic [CNT_W-1:0]            load_lc,
    input  logic [CNT_W-1:0]            load_ec,
    input  logic                        br_top,
    input  logic                        br_cloop,
    input  logic [$clog2(GR_TOTAL)-1:0] gr_virt,
    output logic [$clog2(GR_TOTAL)-1:0] gr_phys,
    input  logic [$clog2(PR_TOTAL)-1:0] pr_virt,
    output logic [$clog2(PR_TOTAL)-1:0] pr_phys,
    output logic                        br_taken,
    output logic                        stage_pred_we,
    output logic                        stage_pred_val,
    output logic [CNT_W-1:0]            lc_o,
    output logic [CNT_W-1:0]            ec_o,
    output logic [$clog2(GR_TOTAL)-1:0] gr_base_o,
    output logic [$clog2(PR_TOTAL)-1:0] pr_base_o
);
    localparam int GR_W   = $clog2(GR_TOTAL);
    localparam int PR_W   = $clog2(PR_TOTAL);
    localparam int GR_ROT = GR_TOTAL - GR_STATIC;
    localparam int PR_ROT = PR_TOTAL - PR_STATIC;

    typedef struct packed {
        logic [CNT_W-1:0] lc;
        logic [CNT_W-1:0] ec;
        logic [GR_W-1:0]  gb;
        logic [PR_W-1:0]  pb;
    } rr_state_t;

    rr_state_t st_d, st_q;

    rr_pkg::rr_kind_e kind;
    logic lc_dec, ec_dec, rotate, taken, pred_we, pred_val;

    rr_loop_ctl #(.CNT_W(CNT_W)) i_ctl (
        .br_top   (br_top),
        .br_cloop (br_cloop),
        .lc       (st_q.lc),
        .ec       (st_q.ec),
        .kind     (kind),
        .lc_dec   (lc_dec),
        .ec_dec   (ec_dec),
        .rotate   (rotate),
        .taken    (taken),
        .pred_we  (pred_we),
        .pred_val (pred_val)
    );

    rr_rename #(.TOTAL(GR_TOTAL), .STATIC(GR_STATIC)) i_gr_ren (
        .base (st_q.gb),
        .virt (gr_virt),
        .phys (gr_phys)
    );

    rr_rename #(.TOTAL(PR_TOTAL), .STATIC(PR_STATIC)) i_pr_ren (
        .base (st_q.pb),
        .virt (pr_virt),
        .phys (pr_phys)
    );

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.lc = load_lc;
            st_d.ec = load_ec;
            st_d.gb = '0;
            st_d.pb = '0;
        end else begin
            if (lc_dec) st_d.lc = st_q.lc - 1'b1;
            if (ec_dec) st_d.ec = st_q.ec - 1'b1;
            if (rotate) begin
                st_d.gb = (st_q.gb == '0) ? GR_W'(GR_ROT - 1) : st_q.gb - 1'b1;
                st_d.pb = (st_q.pb == '0) ? PR_W'(PR_ROT - 1) : st_q.pb - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign br_taken       = taken    & ~load_en;
    assign stage_pred_we  = pred_we  & ~load_en;
    assign stage_pred_val = pred_val & ~load_en;
    assign lc_o           = st_q.lc;
    assign ec_o           = st_q.ec;
    assign gr_base_o      = st_q.gb;
    assign pr_base_o      = st_q.pb;
endmodule

// File: rtl/rr_checker.sv
`timescale 1ns/1ps
module rr_checker #(
    parameter int GR_TOTAL  = 128,
    parameter int GR_STATIC = 32,
    parameter int PR_TOTAL  = 64,
    parameter int PR_STATIC = 16,
    parameter int CNT_W     = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        load_en,
    input logic [CNT_W-1:0]            load_lc,
    input logic [CNT_W-1:0]            load_ec,
    input logic                        br_top,
    input logic                        br_cloop,
    input logic [$clog2(GR_TOTAL)-1:0] gr_virt,
    input logic [$clog2(GR_TOTAL)-1:0] gr_phys,
    input logic [$clog2(PR_TOTAL)-1:0] pr_virt,
    input logic [$clog2(PR_TOTAL)-1:0] pr_phys,
    input logic                        br_taken,
    input logic                        stage_pred_we,
    input logic                        stage_pred_val,
    input logic [CNT_W-1:0]            lc_o,
    input logic [CNT_W-1:0]            ec_o,
    input logic [$clog2(GR_TOTAL)-1:0] gr_base_o,
    input logic [$clog2(PR_TOTAL)-1:0] pr_base_o
);
    localparam int GR_W   = $clog2(GR_TOTAL);
    localparam int PR_W   = $clog2(PR_TOTAL);
    localparam int GR_ROT = GR_TOTAL - GR_STATIC;
    localparam int PR_ROT = PR_TOTAL - PR_STATIC;

    logic ld_q;
    logic [CNT_W-1:0] lld_q, eld_q;
    always_ff @(posedge clk) begin
        ld_q  <= load_en;
        lld_q <= load_lc;
        eld_q <= load_ec;
    end

    a_r1_static_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (gr_virt < GR_W'(GR_STATIC) && pr_virt < PR_W'(PR_STATIC))
        |-> (gr_phys == gr_virt && pr_phys == pr_virt));

    a_r2_gr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (gr_virt >= GR_W'(GR_STATIC)) |-> (gr_phys >= GR_W'(GR_STATIC)));

    a_r3_pr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_virt >= PR_W'(PR_STATIC)) |-> (pr_phys >= PR_W'(PR_STATIC)));

    a_r4_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
        ld_q |-> (lc_o == lld_q && ec_o == eld_q && gr_base_o == '0 && pr_base_o == '0));

    a_r4_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (!br_taken && !stage_pred_we));

    a_r5_kernel_out: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && br_top && lc_o != '0) |-> (br_taken && stage_pred_we && stage_pred_val));

    a_r5_base_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && br_top && (lc_o != '0 || ec_o != '0))
        |=> (gr_base_o == (($past(gr_base_o) == '0) ? GR_W'(GR_ROT - 1) : GR_W'($past(gr_base_o) - 1'b1))
          && pr_base_o == (($past(pr_base_o) == '0) ? PR_W'(PR_ROT - 1) : PR_W'($past(pr_base_o) - 1'b1))));

    a_r6_epilog_out: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && br_top && lc_o == '0 && ec_o > CNT_W'(1))
        |-> (br_taken && stage_pred_we && !stage_pred_val));

    a_r7_drain_out: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && br_top && lc_o == '0 && ec_o == CNT_W'(1))
        |-> (!br_taken && stage_pred_we && !stage_pred_val));

    a_r8_spent_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && br_top && lc_o == '0 && ec_o == '0)
        |=> ($stable(gr_base_o) && $stable(pr_base_o) && $stable(ec_o) && $stable(lc_o)));

    a_r9_cloop_norot: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !br_top && br_cloop)
        |=> ($stable(gr_base_o) && $stable(pr_base_o) && $stable(ec_o)));

    a_r9_cloop_nopred: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_top && br_cloop) |-> !stage_pred_we);

    a_r5_val_only_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        stage_pred_val |-> (stage_pred_we && br_taken));
endmodule

bind rot_rename_loop rr_checker #(
    .GR_TOTAL(GR_TOTAL), .GR_STATIC(GR_STATIC),
    .PR_TOTAL(PR_TOTAL), .PR_STATIC(PR_STATIC), .CNT_W(CNT_W)
) i_rr_checker (.*);

// File: tb/test_rot_rename_loop.sv
`timescale 1ns/1ps
module test_rot_rename_loop;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_en = 1'b0;
    logic [CNT_W-1:0] load_lc = '0, load_ec = '0;
    logic br_top = 1'b0, br_cloop = 1'b0;
    logic [6:0] gr_virt = '0, gr_phys;
    logic [5:0] pr_virt = '0, pr_phys;
    logic br_taken, stage_pred_we, stage_pred_val;
    logic [CNT_W-1:0] lc_o, ec_o;
    logic [6:0] gr_base_o;
    logic [5:0] pr_base_o;

    int checks = 0;
    int errors = 0;
    int m_lc = 0, m_ec = 0, m_gb = 0, m_pb = 0;

    always #2 clk = ~clk;  // 250 MHz

    rot_rename_loop i_rot_rename_loop (.*);

    function automatic int f_gr(int v, int b);
        if (v < 32) return v;
        return 32 + ((v - 32 + b) % 96);
    endfunction

    function automatic int f_pr(int v, int b);
        if (v < 16) return v;
        return 16 + ((v - 16 + b) % 48);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_state(string req);
        chk(int'(lc_o) == m_lc, req, "loop counter", int'(lc_o), m_lc);
        chk(int'(ec_o) == m_ec, req, "epilogue counter", int'(ec_o), m_ec);
        chk(int'(gr_base_o) == m_gb, req, "general base", int'(gr_base_o), m_gb);
        chk(int'(pr_base_o) == m_pb, req, "predicate base", int'(pr_base_o), m_pb);
    endtask

    // one cycle: drive, check combinational outputs, clock, check state
    task automatic step(bit ld, int lc, int ec, bit top, bit cl, int gv, int pv, string req);
        bit e_tk, e_we, e_val, rot;
        load_en = ld; load_lc = CNT_W'(lc); load_ec = CNT_W'(ec);
        br_top = top; br_cloop = cl;
        gr_virt = 7'(gv); pr_virt = 6'(pv);
        #1;
        e_tk = 0; e_we = 0; e_val = 0; rot = 0;
        chk(int'(gr_phys) == f_gr(gv, m_gb), (gv < 32) ? "R1" : "R2", "gr_phys",
            int'(gr_phys), f_gr(gv, m_gb));
        chk(int'(pr_phys) == f_pr(pv, m_pb), (pv < 16) ? "R1" : "R3", "pr_phys",
            int'(pr_phys), f_pr(pv, m_pb));
        if (ld) begin
            m_lc = lc; m_ec = ec; m_gb = 0; m_pb = 0;
        end else if (top) begin
            if (m_lc != 0)      begin m_lc--; e_tk = 1; e_we = 1; e_val = 1; rot = 1; end
            else if (m_ec > 1)  begin m_ec--; e_tk = 1; e_we = 1; rot = 1; end
            else if (m_ec == 1) begin m_ec = 0; e_we = 1; rot = 1; end
        end else if (cl) begin
            if (m_lc != 0) begin m_lc--; e_tk = 1; end
        end
        if (rot) begin
            m_gb = (m_gb + 95) % 96;
            m_pb = (m_pb + 47) % 48;
        end
        chk(br_taken == e_tk, req, "br_taken", int'(br_taken), int'(e_tk));
        chk(stage_pred_we == e_we, req, "stage_pred_we", int'(stage_pred_we), int'(e_we));
        chk(stage_pred_val == e_val, req, "stage_pred_val", int'(stage_pred_val), int'(e_val));
        @(posedge clk); #1;
        chk_state(req);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_state("R4");  // reset state all zero

        // R1: static numbers pass through at base 0
        step(0, 0, 0, 0, 0, 5, 3, "R1");
        // R11: prologue / kernel / epilogue sequence from 3/2
        step(1, 3, 2, 0, 0, 32, 16, "R4");
        step(0, 0, 0, 1, 0, 32, 16, "R5");
        step(0, 0, 0, 1, 0, 32, 16, "R5");
        step(0, 0, 0, 1, 0, 40, 20, "R5");
        step(0, 0, 0, 1, 0, 32, 16, "R6");
        step(0, 0, 0, 1, 0, 32, 16, "R7");
        chk(int'(gr_base_o) == 91 && int'(pr_base_o) == 43, "R11", "bases -5",
            int'(gr_base_o), 91);
        // R8: spent counters do nothing
        step(0, 0, 0, 1, 0, 127, 63, "R8");
        // R2: base -1 maps virtual 32 to 127
        step(1, 1, 1, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 0, 32, 16, "R5");
        step(0, 0, 0, 0, 0, 32, 16, "R2");
        chk(int'(gr_phys) == 127 && int'(pr_phys) == 63, "R2", "base -1 wrap",
            int'(gr_phys), 127);
        // R9: counted branch, then exhausted
        step(1, 2, 4, 0, 0, 31, 15, "R4");
        step(0, 0, 0, 0, 1, 64, 30, "R9");
        step(0, 0, 0, 0, 1, 64, 30, "R9");
        step(0, 0, 0, 0, 1, 64, 30, "R9");
        // R10: both strobes together, loop-top wins
        step(1, 2, 2, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 1, 100, 50, "R10");
        // R4: load overrides a strobe
        step(1, 7, 3, 1, 1, 33, 17, "R4");

        // random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            bit ld = (r < 5);
            bit tp = (r >= 5 && r < 70) || (r >= 95);
            bit cl = (r >= 70);
            string req;
            if (ld) req = "R4";
            else if (tp && cl) req = "R10";
            else if (tp) req = (m_lc != 0) ? "R5" : (m_ec > 1) ? "R6" : (m_ec == 1) ? "R7" : "R8";
            else if (cl) req = "R9";
            else req = "R1";
            step(ld, $urandom_range(0, 6), $urandom_range(0, 4), tp, cl,
                 $urandom_range(0, 127), $urandom_range(0, 63), req);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule